// File: doc/BRIEF.md
# String Operation Engine

This block runs one string operation at a time for a processor with segmented addressing. A start pulse hands it an operation kind, an element size, the direction flag, a repeat mode, the source and destination segment and offset, a count, an accumulator value and a port number. The engine then works through the elements of the string one at a time. Each element takes one or two accesses on a memory request port or an I/O port, and both ports use a valid/ready handshake. When the operation ends the engine returns the updated offsets, the remaining count, the accumulator and the compare flags.

There are seven operation kinds: move, compare, load, store, scan, port input and port output. Each kind reads and writes its own subset of source, destination, accumulator and port. The engine steps only the offsets that the kind uses. The step equals the element size, and the direction flag sets its sign. The caller selects the repeat mode. A plain repeat runs until the count is exhausted. The two conditional modes can also stop early on the zero flag left by a compare or a scan.

Top module: `strEngine`

## Requirements
- R1: An element is 1, 2 or 4 bytes for elemSize 0, 1 or 2. After each element, every offset that the operation uses changes by exactly that byte count.
- R2: With dirFlag 0 the used offsets increase, and with dirFlag 1 they decrease. Offsets wrap modulo 2^16. The memory address is segment*16 + offset, taken modulo 2^20.
- R3: Move (opKind 0) reads the source element, writes it to the destination element, and steps both offsets.
- R4: Compare (opKind 1) reads the source element and then the destination element. It sets zeroFlag when they are equal. It sets carryFlag when source < destination, both taken unsigned. It sets signFlag to the top bit, at the element size, of (source - destination). It steps both offsets. Only opKinds 1 and 4 change the flags, and the flags are 0 after reset.
- R5: Load (opKind 2) replaces the low 8, 16 or 32 bits of the accumulator with the source element. The upper bits are kept, and only the source offset steps.
- R6: Store (opKind 3) writes the low element of the accumulator to the destination. Scan (opKind 4) sets the flags as for R4, using the accumulator element in place of the source and the destination element as the second operand. Both step only the destination offset.
- R7: Port input (opKind 5) reads the element from the port numbered portNum, writes it to the destination, and steps only the destination offset.
- R8: Port output (opKind 6) reads the source element, steps only the source offset, and writes the element to port portNum.
- R9: repMode 0 processes exactly one element and leaves the count unchanged. repModes 1, 2 and 3 decrement the count after each element and stop when it reaches 0. A count of 0 at the start gives no access at all and unchanged registers.
- R10: repMode 2 also stops after a compare or scan element that leaves zeroFlag clear. repMode 3 stops after one that leaves zeroFlag set. For the other kinds, both modes act like repMode 1.
- R11: At most one access is requested at a time, and memValid and ioValid are never high together. A request keeps its address and its write direction until ready is seen. Each element makes exactly the accesses its kind needs, and no others.
- R12: done is high for exactly one cycle per accepted start, and busy is low in that cycle. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opKind | input | 3 | Operation kind 0..6 |
| elemSize | input | 2 | Element size code 0/1/2 = 1/2/4 bytes |
| dirFlag | input | 1 | 0 = increment offsets, 1 = decrement |
| repMode | input | 2 | 0 none, 1 count, 2 while equal, 3 while not equal |
| srcSeg | input | 16 | Source segment |
| srcOff | input | 16 | Initial source offset |
| dstSeg | input | 16 | Destination segment |
| dstOff | input | 16 | Initial destination offset |
| countIn | input | 16 | Initial repeat count |
| accIn | input | 32 | Initial accumulator |
| portNum | input | 16 | I/O port number |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | 20 | Memory byte address |
| memWdata | output | 32 | Write data, element in low bytes |
| xferSize | output | 2 | Element size code of the current access |
| memReady | input | 1 | Memory accepts the request |
| memRdata | input | 32 | Read data, valid with memReady |
| ioValid | output | 1 | Port request valid |
| ioWrite | output | 1 | Port request is an output |
| ioAddr | output | 16 | Port number |
| ioWdata | output | 32 | Port output data |
| ioReady | input | 1 | Port accepts the request |
| ioRdata | input | 32 | Port input data, valid with ioReady |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| srcOffOut | output | 16 | Current source offset |
| dstOffOut | output | 16 | Current destination offset |
| countOut | output | 16 | Current count |
| accOut | output | 32 | Current accumulator |
| zeroFlag | output | 1 | Compare result zero |
| carryFlag | output | 1 | Compare borrow |
| signFlag | output | 1 | Compare result sign |

## Verification
The hardest case to reach is early termination of the conditional repeat modes. With arbitrary memory contents, a compare almost never matches, so repeat-while-equal stops after one element and repeat-while-not-equal always runs to the count. The stimulus therefore preloads memory with equal runs that end in a planted mismatch, and places the accumulator's value at a chosen distance into a scanned string. Memory and port ready are both withheld at random, so requests must stay stable across stalls. Every run also pulses start again one cycle after launch to show that the engine ignores it while busy.

// File: rtl/strEnginePkg.sv
package strEnginePkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_SCAN  = 3'd4,
    OP_PIN   = 3'd5,
    OP_POUT  = 3'd6
  } opKindT;

  typedef enum logic [1:0] {
    REP_NONE  = 2'd0,
    REP_COUNT = 2'd1,
    REP_EQ    = 2'd2,
    REP_NE    = 2'd3
  } repT;

  typedef enum logic [2:0] {
    S_IDLE, S_PRECHK, S_RDSRC, S_RDDST, S_RDPORT, S_WRDST, S_WRPORT, S_STEP
  } stateT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadRegs;  // latch operation inputs
    logic latchMem;  // capture memory read into the element holder
    logic latchIo;   // capture port read into the element holder
    logic accLoad;   // merge memory read into the accumulator
    logic cmpNow;    // evaluate flags against the memory read
    logic stepElem;  // advance offsets and count
    logic addrDst;   // address the destination side
  } ctrlT;

endpackage

// File: rtl/strDatapath.sv
module strDatapath
  import strEnginePkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 32,
  parameter int PORT_W    = 16,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT,
  localparam int BITS_W   = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [2:0]        opIn,
  input  logic [1:0]        sizeIn,
  input  logic              dirIn,
  input  logic [1:0]        repIn,
  input  logic [SEG_W-1:0]  srcSegIn,
  input  logic [OFF_W-1:0]  srcOffIn,
  input  logic [SEG_W-1:0]  dstSegIn,
  input  logic [OFF_W-1:0]  dstOffIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [PORT_W-1:0] portIn,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] ioRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [PORT_W-1:0] ioAddr,
  output logic [DATA_W-1:0] ioWdata,
  output logic [1:0]        xferSize,
  output opKindT            opQ,
  output repT               repQ,
  output logic              cntZero,
  output logic              cntOne,
  output logic [OFF_W-1:0]  srcOffQ,
  output logic [OFF_W-1:0]  dstOffQ,
  output logic [CNT_W-1:0]  countQ,
  output logic [DATA_W-1:0] accQ,
  output logic              zfQ,
  output logic              cfQ,
  output logic              sfQ
);

  logic [1:0]        sizeQ;
  logic              dirQ;
  logic [SEG_W-1:0]  srcSegQ, dstSegQ;
  logic [PORT_W-1:0] portQ;
  logic [DATA_W-1:0] elemQ;

  logic [2:0]        elemBytes;
  logic [BITS_W-1:0] elemBits;
  logic [DATA_W-1:0] mask, topBit;
  logic [OFF_W-1:0]  stepAmt, srcNext, dstNext;
  logic [DATA_W-1:0] lhs, rhs, diffRes;
  logic [DATA_W:0]   diffWide;
  logic              usesSrc, usesDst;

  assign elemBytes = (sizeQ == 2'd0) ? 3'd1 : (sizeQ == 2'd1) ? 3'd2 : 3'd4;
  assign elemBits  = BITS_W'(elemBytes) << 3;
  assign mask      = ~({DATA_W{1'b1}} << elemBits);
  assign topBit    = mask & ~(mask >> 1);
  assign stepAmt   = OFF_W'(elemBytes);
  assign srcNext   = dirQ ? srcOffQ - stepAmt : srcOffQ + stepAmt;
  assign dstNext   = dirQ ? dstOffQ - stepAmt : dstOffQ + stepAmt;

  assign usesSrc = (opQ == OP_MOVE) || (opQ == OP_CMP) || (opQ == OP_LOAD) || (opQ == OP_POUT);
  assign usesDst = (opQ != OP_LOAD) && (opQ != OP_POUT);

  // subtraction for compare and scan, first operand picked by kind
  assign lhs      = ((opQ == OP_SCAN) ? accQ : elemQ) & mask;
  assign rhs      = memRdata & mask;
  assign diffWide = {1'b0, lhs} - {1'b0, rhs};
  assign diffRes  = diffWide[DATA_W-1:0] & mask;

  assign memAddr  = ctrl.addrDst ? ({dstSegQ, {SEG_SHIFT{1'b0}}} + ADDR_W'(dstOffQ))
                                 : ({srcSegQ, {SEG_SHIFT{1'b0}}} + ADDR_W'(srcOffQ));
  assign memWdata = (opQ == OP_STORE) ? (accQ & mask) : elemQ;
  assign ioAddr   = portQ;
  assign ioWdata  = elemQ;
  assign xferSize = sizeQ;
  assign cntZero  = (countQ == '0);
  assign cntOne   = (countQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= OP_MOVE;
      repQ    <= REP_NONE;
      sizeQ   <= '0;
      dirQ    <= 1'b0;
      srcSegQ <= '0;
      dstSegQ <= '0;
      srcOffQ <= '0;
      dstOffQ <= '0;
      countQ  <= '0;
      accQ    <= '0;
      portQ   <= '0;
      elemQ   <= '0;
      zfQ     <= 1'b0;
      cfQ     <= 1'b0;
      sfQ     <= 1'b0;
    end else begin
      if (ctrl.loadRegs) begin
        opQ     <= opKindT'(opIn);
        repQ    <= repT'(repIn);
        sizeQ   <= sizeIn;
        dirQ    <= dirIn;
        srcSegQ <= srcSegIn;
        dstSegQ <= dstSegIn;
        srcOffQ <= srcOffIn;
        dstOffQ <= dstOffIn;
        countQ  <= countIn;
        accQ    <= accIn;
        portQ   <= portIn;
      end
      if (ctrl.latchMem) elemQ <= memRdata & mask;
      if (ctrl.latchIo)  elemQ <= ioRdata & mask;
      if (ctrl.accLoad)  accQ  <= (accQ & ~mask) | (memRdata & mask);
      if (ctrl.cmpNow) begin
        zfQ <= (diffRes == '0);
        cfQ <= diffWide[DATA_W];
        sfQ <= |(diffRes & topBit);
      end
      if (ctrl.stepElem) begin
        if (usesSrc) srcOffQ <= srcNext;
        if (usesDst) dstOffQ <= dstNext;
        if (repQ != REP_NONE) countQ <= countQ - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/strCtrl.sv
module strCtrl
  import strEnginePkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   memReady,
  input  logic   ioReady,
  input  logic   cntZero,
  input  logic   cntOne,
  input  logic   zfQ,
  input  opKindT opQ,
  input  repT    repQ,
  output ctrlT   ctrl,
  output logic   memValid,
  output logic   memWrite,
  output logic   ioValid,
  output logic   ioWrite,
  output logic   busy,
  output logic   done
);

  stateT state, nextState;
  logic  finish, isCmp, stopNow;

  function automatic stateT firstPhase(opKindT op);
    case (op)
      OP_STORE: return S_WRDST;
      OP_SCAN:  return S_RDDST;
      OP_PIN:   return S_RDPORT;
      default:  return S_RDSRC;
    endcase
  endfunction

  function automatic stateT afterSrc(opKindT op);
    case (op)
      OP_MOVE: return S_WRDST;
      OP_CMP:  return S_RDDST;
      OP_POUT: return S_WRPORT;
      default: return S_STEP;
    endcase
  endfunction

  assign isCmp = (opQ == OP_CMP) || (opQ == OP_SCAN);

  always_comb begin
    case (repQ)
      REP_NONE: stopNow = 1'b1;
      REP_EQ:   stopNow = cntOne || (isCmp && !zfQ);
      REP_NE:   stopNow = cntOne || (isCmp && zfQ);
      default:  stopNow = cntOne;
    endcase
  end

  always_comb begin
    ctrl      = '0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    ioValid   = 1'b0;
    ioWrite   = 1'b0;
    finish    = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctrl.loadRegs = 1'b1;
          nextState     = S_PRECHK;
        end
      end
      S_PRECHK: begin
        if ((repQ != REP_NONE) && cntZero) begin
          finish    = 1'b1;
          nextState = S_IDLE;
        end else begin
          nextState = firstPhase(opQ);
        end
      end
      S_RDSRC: begin
        memValid = 1'b1;
        if (memReady) begin
          ctrl.latchMem = 1'b1;
          ctrl.accLoad  = (opQ == OP_LOAD);
          nextState     = afterSrc(opQ);
        end
      end
      S_RDDST: begin
        memValid     = 1'b1;
        ctrl.addrDst = 1'b1;
        if (memReady) begin
          ctrl.cmpNow = 1'b1;
          nextState   = S_STEP;
        end
      end
      S_RDPORT: begin
        ioValid = 1'b1;
        if (ioReady) begin
          ctrl.latchIo = 1'b1;
          nextState    = S_WRDST;
        end
      end
      S_WRDST: begin
        memValid     = 1'b1;
        memWrite     = 1'b1;
        ctrl.addrDst = 1'b1;
        if (memReady) nextState = S_STEP;
      end
      S_WRPORT: begin
        ioValid = 1'b1;
        ioWrite = 1'b1;
        if (ioReady) nextState = S_STEP;
      end
      S_STEP: begin
        ctrl.stepElem = 1'b1;
        if (stopNow) begin
          finish    = 1'b1;
          nextState = S_IDLE;
        end else begin
          nextState = firstPhase(opQ);
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finish;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/strEngine.sv
module strEngine
  import strEnginePkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 32,
  parameter int PORT_W    = 16,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opKind,
  input  logic [1:0]        elemSize,
  input  logic              dirFlag,
  input  logic [1:0]        repMode,
  input  logic [SEG_W-1:0]  srcSeg,
  input  logic [OFF_W-1:0]  srcOff,
  input  logic [SEG_W-1:0]  dstSeg,
  input  logic [OFF_W-1:0]  dstOff,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [PORT_W-1:0] portNum,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [1:0]        xferSize,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              ioValid,
  output logic              ioWrite,
  output logic [PORT_W-1:0] ioAddr,
  output logic [DATA_W-1:0] ioWdata,
  input  logic              ioReady,
  input  logic [DATA_W-1:0] ioRdata,
  output logic              busy,
  output logic              done,
  output logic [OFF_W-1:0]  srcOffOut,
  output logic [OFF_W-1:0]  dstOffOut,
  output logic [CNT_W-1:0]  countOut,
  output logic [DATA_W-1:0] accOut,
  output logic              zeroFlag,
  output logic              carryFlag,
  output logic              signFlag
);

  ctrlT   ctrl;
  opKindT opQ;
  repT    repQ;
  logic   cntZero, cntOne;

  strCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .memReady(memReady), .ioReady(ioReady),
    .cntZero(cntZero), .cntOne(cntOne), .zfQ(zeroFlag),
    .opQ(opQ), .repQ(repQ), .ctrl(ctrl),
    .memValid(memValid), .memWrite(memWrite),
    .ioValid(ioValid), .ioWrite(ioWrite),
    .busy(busy), .done(done)
  );

  strDatapath #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT),
    .CNT_W(CNT_W), .DATA_W(DATA_W), .PORT_W(PORT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .opIn(opKind), .sizeIn(elemSize), .dirIn(dirFlag), .repIn(repMode),
    .srcSegIn(srcSeg), .srcOffIn(srcOff), .dstSegIn(dstSeg), .dstOffIn(dstOff),
    .countIn(countIn), .accIn(accIn), .portIn(portNum),
    .memRdata(memRdata), .ioRdata(ioRdata),
    .memAddr(memAddr), .memWdata(memWdata), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .xferSize(xferSize), .opQ(opQ), .repQ(repQ),
    .cntZero(cntZero), .cntOne(cntOne),
    .srcOffQ(srcOffOut), .dstOffQ(dstOffOut), .countQ(countOut), .accQ(accOut),
    .zfQ(zeroFlag), .cfQ(carryFlag), .sfQ(signFlag)
  );

endmodule

// File: rtl/strEngineChk.sv
module strEngineChk #(
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        elemSize,
  input logic              dirFlag,
  input logic [1:0]        repMode,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady,
  input logic              ioValid,
  input logic              ioWrite,
  input logic              ioReady,
  input logic              busy,
  input logic              done,
  input logic [OFF_W-1:0]  srcOffOut,
  input logic [OFF_W-1:0]  dstOffOut,
  input logic [CNT_W-1:0]  countOut
);

  logic [OFF_W-1:0] chkDelta;
  logic [1:0]       chkRep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkDelta <= '0;
      chkRep   <= '0;
    end else if (start && !busy) begin
      chkRep   <= repMode;
      chkDelta <= dirFlag ? -OFF_W'((elemSize == 2'd0) ? 1 : (elemSize == 2'd1) ? 2 : 4)
                          :  OFF_W'((elemSize == 2'd0) ? 1 : (elemSize == 2'd1) ? 2 : 4);
    end
  end

  p_single_access_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(memValid && ioValid));

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  p_io_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && !ioReady) |=> (ioValid && $stable(ioWrite)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R1 and R2: a running offset only moves by the signed element size
  p_src_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (srcOffOut != $past(srcOffOut)))
      |-> (srcOffOut == $past(srcOffOut) + chkDelta));

  p_dst_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (dstOffOut != $past(dstOffOut)))
      |-> (dstOffOut == $past(dstOffOut) + chkDelta));

  p_zero_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (chkRep != 2'd0) && (countOut == '0)) |-> (!memValid && !ioValid));

endmodule

bind strEngine strEngineChk #(.OFF_W(OFF_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .elemSize(elemSize), .dirFlag(dirFlag),
  .repMode(repMode), .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
  .memReady(memReady), .ioValid(ioValid), .ioWrite(ioWrite), .ioReady(ioReady),
  .busy(busy), .done(done), .srcOffOut(srcOffOut), .dstOffOut(dstOffOut),
  .countOut(countOut)
);

// File: tb/tb_strEngine.sv
`timescale 1ns/1ps
module tb_strEngine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opKind = '0;
  logic [1:0]  elemSize = '0;
  logic        dirFlag = 1'b0;
  logic [1:0]  repMode = '0;
  logic [15:0] srcSeg = '0, srcOff = '0, dstSeg = '0, dstOff = '0, countIn = '0, portNum = '0;
  logic [31:0] accIn = '0;
  logic        memValid, memWrite, ioValid, ioWrite, busy, done;
  logic [19:0] memAddr;
  logic [31:0] memWdata, ioWdata, accOut;
  logic [1:0]  xferSize;
  logic [15:0] ioAddr, srcOffOut, dstOffOut, countOut;
  logic        memReady = 1'b0, ioReady = 1'b0;
  logic [31:0] memRdata = '0, ioRdata = '0;
  logic        zeroFlag, carryFlag, signFlag;

  strEngine dut (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .elemSize(elemSize),
    .dirFlag(dirFlag), .repMode(repMode), .srcSeg(srcSeg), .srcOff(srcOff),
    .dstSeg(dstSeg), .dstOff(dstOff), .countIn(countIn), .accIn(accIn), .portNum(portNum),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .xferSize(xferSize), .memReady(memReady), .memRdata(memRdata),
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioReady(ioReady), .ioRdata(ioRdata), .busy(busy), .done(done),
    .srcOffOut(srcOffOut), .dstOffOut(dstOffOut), .countOut(countOut), .accOut(accOut),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag), .signFlag(signFlag)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0]  mem [int];
  logic [7:0]  refMem [int];
  logic [31:0] gotOut [$];
  logic [31:0] expOut [$];
  int pinCnt = 0, refPin = 0, accCnt = 0, doneCnt = 0, curBytes = 1;
  bit portBad = 0;
  logic [15:0] curPort = '0;
  logic [15:0] eSrc, eDst, eCnt;
  logic [31:0] eAcc;
  logic eZf = 0, eCf = 0, eSf = 0;
  int eAccesses;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] patB(int a);
    return 8'(a ^ (a >> 8) ^ 32'h5A);
  endfunction

  function automatic int linA(logic [15:0] seg, logic [15:0] off);
    return int'(({seg, 4'h0} + {4'h0, off}) & 20'hFFFFF);
  endfunction

  function automatic logic [31:0] bmask(int n);
    return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
  endfunction

  function automatic logic [31:0] pinVal(int k);
    return (32'(k) * 32'h9E37_79B1) ^ 32'h0000_1234;
  endfunction

  function automatic logic [31:0] rdMem(int base, int n);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) begin
      int a = (base + k) & 32'hFFFFF;
      v[8*k +: 8] = mem.exists(a) ? mem[a] : patB(a);
    end
    return v;
  endfunction

  function automatic logic [31:0] rdRef(int base, int n);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) begin
      int a = (base + k) & 32'hFFFFF;
      v[8*k +: 8] = refMem.exists(a) ? refMem[a] : patB(a);
    end
    return v;
  endfunction

  function automatic void wrRef(int base, int n, logic [31:0] v);
    for (int k = 0; k < n; k++) refMem[(base + k) & 32'hFFFFF] = v[8*k +: 8];
  endfunction

  function automatic void expFlags(logic [31:0] a, logic [31:0] b, int n);
    logic [31:0] m = bmask(n);
    logic [31:0] d = ((a & m) - (b & m)) & m;
    eZf = ((a & m) == (b & m));
    eCf = ((a & m) < (b & m));
    eSf = d[8*n-1];
  endfunction

  // memory and port responder, acting between clock edges
  always @(negedge clk) begin
    if (done) doneCnt++;
    memReady = ($urandom % 4) != 0;
    ioReady  = ($urandom % 3) != 0;
    memRdata = $urandom;
    ioRdata  = $urandom;
    if (memValid && memReady) begin
      accCnt++;
      if (memWrite) begin
        for (int k = 0; k < curBytes; k++) mem[(int'(memAddr) + k) & 32'hFFFFF] = memWdata[8*k +: 8];
      end else begin
        memRdata = rdMem(int'(memAddr), curBytes);
      end
    end
    if (ioValid && ioReady) begin
      accCnt++;
      if (ioAddr != curPort) portBad = 1;
      if (ioWrite) gotOut.push_back(ioWdata & bmask(curBytes));
      else begin
        ioRdata = pinVal(pinCnt);
        pinCnt++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // independent model of one whole operation
  task automatic refRun(input int op, input int sz, input bit dir, input int rep,
                        input logic [15:0] sSeg, input logic [15:0] sOff,
                        input logic [15:0] dSeg, input logic [15:0] dOff,
                        input logic [15:0] cnt, input logic [31:0] acc);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    logic [15:0] st = dir ? -16'(n) : 16'(n);
    logic [31:0] m = bmask(n);
    logic [31:0] v, w;
    bit useS = (op == 0) || (op == 1) || (op == 2) || (op == 6);
    bit useD = (op != 2) && (op != 6);
    bit cmpOp = (op == 1) || (op == 4);
    eAccesses = 0;
    expOut.delete();
    if (!(rep != 0 && cnt == 0)) begin
      while (1) begin
        case (op)
          0: begin v = rdRef(linA(sSeg, sOff), n); wrRef(linA(dSeg, dOff), n, v); eAccesses += 2; end
          1: begin v = rdRef(linA(sSeg, sOff), n); w = rdRef(linA(dSeg, dOff), n);
                   expFlags(v, w, n); eAccesses += 2; end
          2: begin v = rdRef(linA(sSeg, sOff), n); acc = (acc & ~m) | (v & m); eAccesses += 1; end
          3: begin wrRef(linA(dSeg, dOff), n, acc & m); eAccesses += 1; end
          4: begin w = rdRef(linA(dSeg, dOff), n); expFlags(acc, w, n); eAccesses += 1; end
          5: begin v = pinVal(refPin) & m; refPin++; wrRef(linA(dSeg, dOff), n, v); eAccesses += 2; end
          default: begin v = rdRef(linA(sSeg, sOff), n); expOut.push_back(v & m); eAccesses += 2; end
        endcase
        if (useS) sOff = sOff + st;
        if (useD) dOff = dOff + st;
        if (rep == 0) break;
        cnt = cnt - 16'd1;
        if (cnt == 0) break;
        if (rep == 2 && cmpOp && !eZf) break;
        if (rep == 3 && cmpOp && eZf) break;
      end
    end
    eSrc = sOff; eDst = dOff; eCnt = cnt; eAcc = acc;
  endtask

  function automatic string tagFor(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic runOp(input int op, input int sz, input bit dir, input int rep,
                       input logic [15:0] sSeg, input logic [15:0] sOff,
                       input logic [15:0] dSeg, input logic [15:0] dOff,
                       input logic [15:0] cnt, input logic [31:0] acc,
                       input logic [15:0] port, input string tag);
    bit memOk = 1, outOk;
    int guard = 0;
    refMem = mem;
    refPin = pinCnt;
    refRun(op, sz, dir, rep, sSeg, sOff, dSeg, dOff, cnt, acc);
    gotOut.delete();
    accCnt = 0; doneCnt = 0; portBad = 0;
    curBytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    curPort = port;
    @(negedge clk);
    opKind = 3'(op); elemSize = 2'(sz); dirFlag = dir; repMode = 2'(rep);
    srcSeg = sSeg; srcOff = sOff; dstSeg = dSeg; dstOff = dOff;
    countIn = cnt; accIn = acc; portNum = port; start = 1'b1;
    @(negedge clk);
    // second start while busy, with different inputs: must be ignored (R12)
    opKind = 3'((op + 3) % 7); srcOff = ~sOff; dstOff = ~dOff; countIn = 16'd9; accIn = ~acc;
    @(negedge clk);
    start = 1'b0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(srcOffOut == eSrc, "R1 R2", {tag, " source offset"}, 32'(srcOffOut), 32'(eSrc));
    chk(dstOffOut == eDst, "R1 R2", {tag, " destination offset"}, 32'(dstOffOut), 32'(eDst));
    chk(countOut == eCnt, "R9 R10", {tag, " count"}, 32'(countOut), 32'(eCnt));
    chk(accOut == eAcc, tag, "accumulator", accOut, eAcc);
    chk({zeroFlag, carryFlag, signFlag} == {eZf, eCf, eSf}, "R4", {tag, " flags zf,cf,sf"},
        32'({zeroFlag, carryFlag, signFlag}), 32'({eZf, eCf, eSf}));
    foreach (mem[k]) if (!refMem.exists(k) || refMem[k] != mem[k]) memOk = 0;
    foreach (refMem[k]) if (!mem.exists(k)) memOk = 0;
    chk(memOk, tag, "memory contents", 32'(memOk), 32'd1);
    outOk = (gotOut.size() == expOut.size());
    if (outOk) foreach (expOut[i]) if (gotOut[i] != expOut[i]) outOk = 0;
    chk(outOk, "R8", {tag, " port output stream"}, 32'(gotOut.size()), 32'(expOut.size()));
    chk(!portBad, "R7 R8", {tag, " port number"}, 32'(portBad), 32'd0);
    chk(accCnt == eAccesses, "R11", {tag, " access count"}, 32'(accCnt), 32'(eAccesses));
    chk(doneCnt == 1, "R12", {tag, " done pulses"}, 32'(doneCnt), 32'd1);
    chk(!done && !busy, "R12", {tag, " idle after done"}, 32'({done, busy}), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R12", "reset busy/done", 32'({busy, done}), 32'd0);
    chk(!memValid && !ioValid, "R11", "reset requests", 32'({memValid, ioValid}), 32'd0);
    chk({zeroFlag, carryFlag, signFlag} == 3'b000, "R4", "reset flags",
        32'({zeroFlag, carryFlag, signFlag}), 32'd0);

    // directed cases
    runOp(0, 0, 0, 0, 16'h0100, 16'h0010, 16'h0200, 16'h0020, 16'd7, 32'h0, 16'h0, "R3");
    runOp(0, 2, 1, 1, 16'h0100, 16'h0004, 16'h0300, 16'h0040, 16'd5, 32'h0, 16'h0, "R3 R2 R9");
    runOp(0, 1, 0, 1, 16'h0100, 16'h0030, 16'h0300, 16'h0050, 16'd0, 32'h0, 16'h0, "R9 zero count");
    runOp(2, 0, 0, 0, 16'h0400, 16'h0001, 16'h0, 16'h0, 16'd3, 32'hAABB_CCDD, 16'h0, "R5 byte");
    runOp(2, 1, 1, 2, 16'h0400, 16'h0011, 16'h0, 16'h0, 16'd3, 32'h1122_3344, 16'h0, "R5 word");
    // equal run of 3 bytes then a mismatch: repeat-while-equal stops after 4
    for (int k = 0; k < 3; k++) begin
      mem[linA(16'h0500, 16'(k))] = 8'(8'h30 + k);
      mem[linA(16'h0600, 16'(k))] = 8'(8'h30 + k);
    end
    mem[linA(16'h0500, 16'd3)] = 8'h10;
    mem[linA(16'h0600, 16'd3)] = 8'h20;
    runOp(1, 0, 0, 2, 16'h0500, 16'h0000, 16'h0600, 16'h0000, 16'd10, 32'h0, 16'h0, "R10 R4 while-equal");
    // accumulator value planted at the third byte: repeat-while-not-equal stops after 3
    mem[linA(16'h0700, 16'd2)] = 8'h00;
    mem[linA(16'h0700, 16'd0)] = 8'h01;
    mem[linA(16'h0700, 16'd1)] = 8'h02;
    runOp(4, 0, 0, 3, 16'h0, 16'h0, 16'h0700, 16'h0000, 16'd8, 32'hFFFF_FF00, 16'h0, "R10 R6 while-not-equal");
    runOp(3, 1, 0, 1, 16'h0, 16'h0, 16'h0800, 16'hFFFE, 16'd3, 32'hDEAD_BEEF, 16'h0, "R6 store wrap");
    runOp(5, 2, 0, 1, 16'h0, 16'h0, 16'h0900, 16'h0100, 16'd4, 32'h0, 16'h0378, "R7");
    runOp(6, 1, 1, 1, 16'h0A00, 16'h0200, 16'h0, 16'h0, 16'd3, 32'h0, 16'h00F0, "R8");
    runOp(3, 0, 0, 2, 16'h0, 16'h0, 16'h0B00, 16'h0000, 16'd4, 32'h5A, 16'h0, "R10 non-compare");

    // constrained random operations
    for (int t = 0; t < 80; t++) begin
      int op = $urandom % 7;
      runOp(op, $urandom % 3, 1'($urandom % 2), $urandom % 4,
            16'($urandom % 64), 16'($urandom), 16'($urandom % 64), 16'($urandom),
            16'($urandom % 7), $urandom, 16'($urandom), tagFor(op));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule